// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Two-Step Fill

This block is a small, fully associative address translation buffer. Each slot holds an inclusive virtual range (first and last byte address), a physical page number, an access-rights record (access id, user bit, read and write privilege levels, rights type, break, dirty and trap-on-reference bits) and a valid flag. A slot matches an address by range comparison rather than by tag equality. When several slots match, the lowest index wins.

A slot is filled in two steps. An insert-address command picks a slot and writes the range and the physical page, but leaves the slot invalid. A later insert-protection command at an address inside that range loads the rights record and makes the slot valid. Two purge commands are provided: one clears the single valid slot that covers an address, and the other clears every slot. A lookup returns hit or miss and the matched slot's fields one cycle later.

All commands enter through one valid/ready channel. `cmd_ready` is held high, so a command is taken in every cycle where `cmd_valid` is high. The result side has no back-pressure. `res_valid` and `prot_err` pulse for exactly one cycle and must be captured by the consumer in that cycle.

Top module: `tlb_range_buf`

## Requirements
- R1: A lookup hits when a slot is valid and its first address is at or below the lookup address and the lookup address is at or below its last address. Pages are 4 KiB, so the last address is the first address plus 0xFFF. On a hit, `res_phys` equals the physical page number shifted left by 12 with the low 12 bits of the lookup address appended.
- R2: Command codes on `cmd_op` are as follows:
  - 1 is lookup.
  - 2 is insert-address.
  - 3 is insert-protection.
  - 4 is purge-one.
  - 5 is purge-all.
  - Other codes do nothing.
  `cmd_ready` is always 1. After every accepted lookup, `res_valid` is 1 on the next cycle, and it is 0 after any other cycle.
- R3: Insert-address sets the slot's first address to the command address with its low 12 bits cleared. It sets the physical page number to `cmd_data` bits 24:5. The slot stays invalid, so a lookup in that page reports a miss (`res_miss`=1, `res_hit`=0) until insert-protection. A miss is reported when no slot covers the address, and also when the covering slot is invalid.
- R4: Insert-protection on a covering invalid slot loads fields from `cmd_data` and sets the slot valid. The field positions are:
  - access id: bits 18:1
  - user bit: bit 19
  - write privilege: bits 21:20
  - read privilege: bits 23:22
  - rights type: bits 26:24
  - break: bit 27
  - dirty: bit 28
  - trap-on-reference: bit 29
  A hit returns exactly these values.
- R5: Insert-protection is ignored when no slot covers the address, or when the covering slot is already valid. In that case `prot_err` is 1 on the next cycle. It is 0 on the cycle after any other command.
- R6: Insert-address clears every valid slot that covers the new address before the new range is written.
- R7: The insert-address target is the highest-index slot that is invalid or was just cleared by R6. When no such slot exists, the slot under a round-robin pointer is overwritten, and the pointer advances from the last index back to 0.
- R8: Purge-one clears the covering slot only when that slot is valid. A covering slot that is still invalid keeps its range and can still complete through insert-protection.
- R9: Purge-all clears every slot, so every following lookup misses.
- R10: After reset every slot is empty and never matches. The round-robin pointer is 0, and `res_valid` and `prot_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | VA_W | Virtual address for the command |
| cmd_data | input | 32 | Physical page word or rights word |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup found a valid covering slot |
| res_miss | output | 1 | Data translation miss |
| res_phys | output | PA_W | Translated physical address |
| res_access_id | output | 18 | Access id of the matched slot |
| res_user_bit | output | 1 | User bit |
| res_wr_priv | output | 2 | Write privilege level |
| res_rd_priv | output | 2 | Read privilege level |
| res_rights | output | 3 | Rights type |
| res_brk | output | 1 | Break bit |
| res_dirty | output | 1 | Dirty bit |
| res_tref | output | 1 | Trap-on-reference bit |
| prot_err | output | 1 | Insert-protection was rejected |

## Verification
Both results are due exactly one rising edge after the command that causes them. The lookup fields and `res_valid` follow a lookup, and `prot_err` follows an insert-protection. A command also affects a lookup issued on the very next cycle. The driver applies one command on each falling edge and pushes exactly one expectation per cycle, with idle cycles included. The monitor samples 2 ns after each rising edge and pops one expectation, so every result is compared in the one cycle it is due and an extra or missing pulse is caught.

// File: rtl/tlb_rb_pkg.sv
package tlb_rb_pkg;
  localparam int PPN_W  = 20;
  localparam int PPN_LO = 5;

  localparam logic [2:0] OP_LOOKUP    = 3'd1;
  localparam logic [2:0] OP_INS_ADDR  = 3'd2;
  localparam logic [2:0] OP_INS_PROT  = 3'd3;
  localparam logic [2:0] OP_PURGE_ONE = 3'd4;
  localparam logic [2:0] OP_PURGE_ALL = 3'd5;

  // Packed so that a cast of data bits 29:1 lands every field in place.
  typedef struct packed {
    logic        tref;
    logic        dirty;
    logic        brk;
    logic [2:0]  rights;
    logic [1:0]  rd_priv;
    logic [1:0]  wr_priv;
    logic        user_bit;
    logic [17:0] access_id;
  } rights_t;
endpackage

// File: rtl/tlb_rb_store.sv
module tlb_rb_store
  import tlb_rb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_all,
  input  logic [ENTRIES-1:0]     clr_vec,
  input  logic                   wr_addr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VA_W-1:0]        wr_first,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   wr_prot_en,
  input  logic [IDX_W-1:0]       prot_idx,
  input  rights_t                prot_data,
  output logic [VA_W-1:0]        va_first [ENTRIES],
  output logic [VA_W-1:0]        va_last  [ENTRIES],
  output logic [PPN_W-1:0]       ppn      [ENTRIES],
  output rights_t                rights   [ENTRIES],
  output logic [ENTRIES-1:0]     valid
);
  localparam logic [VA_W-1:0] PAGE_MASK = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        va_first[i] <= '1;
        va_last[i]  <= '0;
        ppn[i]      <= '0;
        rights[i]   <= '0;
      end
      valid <= '0;
    end else if (clr_all) begin
      for (int i = 0; i < ENTRIES; i++) begin
        va_first[i] <= '1;
        va_last[i]  <= '0;
        ppn[i]      <= '0;
        rights[i]   <= '0;
      end
      valid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_addr_en && wr_idx == IDX_W'(i)) begin
          va_first[i] <= wr_first;
          va_last[i]  <= wr_first | PAGE_MASK;
          ppn[i]      <= wr_ppn;
          rights[i]   <= '0;
          valid[i]    <= 1'b0;
        end else if (clr_vec[i]) begin
          va_first[i] <= '1;
          va_last[i]  <= '0;
          ppn[i]      <= '0;
          rights[i]   <= '0;
          valid[i]    <= 1'b0;
        end
        if (wr_prot_en && prot_idx == IDX_W'(i)) begin
          rights[i] <= prot_data;
          valid[i]  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_rb_match.sv
module tlb_rb_match #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VA_W-1:0]    addr,
  input  logic [VA_W-1:0]    va_first [ENTRIES],
  input  logic [VA_W-1:0]    va_last  [ENTRIES],
  output logic [ENTRIES-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   first_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = (va_first[g] <= addr) && (addr <= va_last[g]);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    any_hit   = 1'b0;
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit   = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_rb_victim.sv
module tlb_rb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [ENTRIES-1:0] free_vec,
  output logic [IDX_W-1:0]   tgt_idx
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] last_free;
  logic             have_free;

  // Highest free index is the one chosen.
  always_comb begin
    have_free = 1'b0;
    last_free = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_vec[i]) begin
        have_free = 1'b1;
        last_free = IDX_W'(i);
      end
    end
  end

  assign tgt_idx = have_free ? last_free : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (take && !have_free) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_range_buf.sv
module tlb_range_buf
  import tlb_rb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [VA_W-1:0] cmd_addr,
  input  logic [31:0]     cmd_data,
  output logic            res_valid,
  output logic            res_hit,
  output logic            res_miss,
  output logic [PA_W-1:0] res_phys,
  output logic [17:0]     res_access_id,
  output logic            res_user_bit,
  output logic [1:0]      res_wr_priv,
  output logic [1:0]      res_rd_priv,
  output logic [2:0]      res_rights,
  output logic            res_brk,
  output logic            res_dirty,
  output logic            res_tref,
  output logic            prot_err
);
  logic [VA_W-1:0]    va_first [ENTRIES];
  logic [VA_W-1:0]    va_last  [ENTRIES];
  logic [PPN_W-1:0]   ppn      [ENTRIES];
  rights_t            rights   [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] clr_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   first_idx;
  logic [IDX_W-1:0]   tgt_idx;
  logic               first_valid;
  logic               is_lk, is_ia, is_ip, is_po, is_pa;
  logic               prot_ok;
  rights_t            hit_rights;

  assign cmd_ready = 1'b1;

  assign is_lk = cmd_valid && (cmd_op == OP_LOOKUP);
  assign is_ia = cmd_valid && (cmd_op == OP_INS_ADDR);
  assign is_ip = cmd_valid && (cmd_op == OP_INS_PROT);
  assign is_po = cmd_valid && (cmd_op == OP_PURGE_ONE);
  assign is_pa = cmd_valid && (cmd_op == OP_PURGE_ALL);

  tlb_rb_match #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_match (
    .addr(cmd_addr), .va_first(va_first), .va_last(va_last),
    .hit_vec(hit_vec), .any_hit(any_hit), .first_idx(first_idx)
  );

  assign first_valid = any_hit && valid[first_idx];
  assign prot_ok     = any_hit && !valid[first_idx];

  // Covering valid slots count as free: they are cleared by the insert.
  tlb_rb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .take(is_ia),
    .free_vec(~valid | hit_vec), .tgt_idx(tgt_idx)
  );

  always_comb begin
    clr_vec = '0;
    if (is_ia) clr_vec = hit_vec & valid;
    if (is_po && first_valid) clr_vec[first_idx] = 1'b1;
  end

  tlb_rb_store #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(is_pa), .clr_vec(clr_vec),
    .wr_addr_en(is_ia), .wr_idx(tgt_idx),
    .wr_first({cmd_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}}),
    .wr_ppn(cmd_data[PPN_LO+PPN_W-1:PPN_LO]),
    .wr_prot_en(is_ip && prot_ok), .prot_idx(first_idx),
    .prot_data(rights_t'(cmd_data[29:1])),
    .va_first(va_first), .va_last(va_last), .ppn(ppn),
    .rights(rights), .valid(valid)
  );

  assign hit_rights = first_valid ? rights[first_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_miss      <= 1'b0;
      res_phys      <= '0;
      res_access_id <= '0;
      res_user_bit  <= 1'b0;
      res_wr_priv   <= '0;
      res_rd_priv   <= '0;
      res_rights    <= '0;
      res_brk       <= 1'b0;
      res_dirty     <= 1'b0;
      res_tref      <= 1'b0;
      prot_err      <= 1'b0;
    end else begin
      res_valid <= is_lk;
      prot_err  <= is_ip && !prot_ok;
      if (is_lk) begin
        res_hit       <= first_valid;
        res_miss      <= !first_valid;
        res_phys      <= first_valid ? {ppn[first_idx], cmd_addr[PAGE_BITS-1:0]} : '0;
        res_access_id <= hit_rights.access_id;
        res_user_bit  <= hit_rights.user_bit;
        res_wr_priv   <= hit_rights.wr_priv;
        res_rd_priv   <= hit_rights.rd_priv;
        res_rights    <= hit_rights.rights;
        res_brk       <= hit_rights.brk;
        res_dirty     <= hit_rights.dirty;
        res_tref      <= hit_rights.tref;
      end else begin
        res_hit  <= 1'b0;
        res_miss <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_range_buf_chk.sv
module tlb_range_buf_chk
  import tlb_rb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic [VA_W-1:0] cmd_addr,
  input logic            res_valid,
  input logic            res_hit,
  input logic            res_miss,
  input logic [PA_W-1:0] res_phys,
  input logic            prot_err
);
  // R2: every accepted lookup yields a result on the next cycle
  a_r2_res_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LOOKUP) |=> res_valid);

  // R2: no result without a lookup the cycle before
  a_r2_no_spurious_res: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_LOOKUP) |=> !res_valid);

  // R2: the command channel never stalls
  a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);

  // R1: a result is either a hit or a miss
  a_r1_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_miss));

  // R1: the page offset passes through untranslated
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_phys[PAGE_BITS-1:0] == $past(cmd_addr[PAGE_BITS-1:0]));

  // R5: the error flag only follows an insert-protection command
  a_r5_err_only_after_prot: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_INS_PROT) |=> !prot_err);

  // R3: a page just inserted by address is still invalid
  a_r3_fresh_insert_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LOOKUP && $past(cmd_valid && cmd_op == OP_INS_ADDR)
     && cmd_addr[VA_W-1:PAGE_BITS] == $past(cmd_addr[VA_W-1:PAGE_BITS])) |=> res_miss);

  // R9: a lookup right after purge-all misses
  a_r9_purge_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PURGE_ALL) ##1 (cmd_valid && cmd_op == OP_LOOKUP) |=> res_miss);
endmodule

bind tlb_range_buf tlb_range_buf_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .res_valid(res_valid), .res_hit(res_hit),
  .res_miss(res_miss), .res_phys(res_phys), .prot_err(prot_err)
);

// File: tb/tlb_range_buf_bench.sv
`timescale 1ns/1ps
module tlb_range_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        res_valid, res_hit, res_miss;
  logic [31:0] res_phys;
  logic [17:0] res_access_id;
  logic        res_user_bit;
  logic [1:0]  res_wr_priv, res_rd_priv;
  logic [2:0]  res_rights;
  logic        res_brk, res_dirty, res_tref, prot_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tlb_range_buf u_tlb_range_buf (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_phys(res_phys),
    .res_access_id(res_access_id), .res_user_bit(res_user_bit),
    .res_wr_priv(res_wr_priv), .res_rd_priv(res_rd_priv), .res_rights(res_rights),
    .res_brk(res_brk), .res_dirty(res_dirty), .res_tref(res_tref), .prot_err(prot_err)
  );

  // Scoreboard queues, one entry per driven cycle.
  bit          q_res [$];
  bit          q_hit [$];
  logic [31:0] q_phys [$];
  logic [28:0] q_fld [$];
  bit          q_err [$];
  string       q_tag [$];

  function automatic logic [28:0] got_fld();
    return {res_tref, res_dirty, res_brk, res_rights, res_rd_priv,
            res_wr_priv, res_user_bit, res_access_id};
  endfunction

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] data,
                     input bit er, input bit eh, input logic [31:0] ephys,
                     input logic [28:0] efld, input bit eerr, input string tag);
    @(negedge clk);
    cmd_valid = (op != 3'd0);
    cmd_op    = op;
    cmd_addr  = addr;
    cmd_data  = data;
    q_res.push_back(er); q_hit.push_back(eh); q_phys.push_back(ephys);
    q_fld.push_back(efld); q_err.push_back(eerr); q_tag.push_back(tag);
  endtask

  task automatic idle();
    cmd(3'd0, '0, '0, 1'b0, 1'b0, '0, '0, 1'b0, "R2");
  endtask
  task automatic lk_hit(input logic [31:0] a, input logic [31:0] ph, input logic [31:0] pw, input string tag);
    cmd(3'd1, a, '0, 1'b1, 1'b1, ph, pw[29:1], 1'b0, tag);
  endtask
  task automatic lk_miss(input logic [31:0] a, input string tag);
    cmd(3'd1, a, '0, 1'b1, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic ins_a(input logic [31:0] a, input logic [19:0] pg, input string tag);
    cmd(3'd2, a, {7'd0, pg, 5'd0}, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic ins_p(input logic [31:0] a, input logic [31:0] pw, input bit err, input string tag);
    cmd(3'd3, a, pw, 1'b0, 1'b0, '0, '0, err, tag);
  endtask
  task automatic purge1(input logic [31:0] a, input string tag);
    cmd(3'd4, a, '0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic purge_all(input string tag);
    cmd(3'd5, '0, '0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  // Monitor: 2 ns after each rising edge, compare with the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q_res.size() > 0) begin
        bit er, eh, ee;
        logic [31:0] ph;
        logic [28:0] fl;
        string tg;
        er = q_res.pop_front(); eh = q_hit.pop_front(); ph = q_phys.pop_front();
        fl = q_fld.pop_front(); ee = q_err.pop_front(); tg = q_tag.pop_front();
        n_cmp++;
        if (res_valid !== er) fail_line(tg, "res_valid", 64'(res_valid), 64'(er));
        else if (er && (res_hit !== eh || res_miss !== !eh))
          fail_line(tg, "hit/miss", {res_hit, res_miss}, {eh, !eh});
        else if (er && eh && res_phys !== ph) fail_line(tg, "res_phys", 64'(res_phys), 64'(ph));
        else if (er && eh && got_fld() !== fl) fail_line(tg, "fields", 64'(got_fld()), 64'(fl));
        if (prot_err !== ee) begin
          n_cmp++;
          fail_line(tg, "prot_err", 64'(prot_err), 64'(ee));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] PW1 = 32'h3A5A_5A5A;
  localparam logic [31:0] PW2 = 32'h1C3C_96A4;
  localparam logic [31:0] PWN = 32'h0123_4566;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (res_valid !== 1'b0 || prot_err !== 1'b0 || cmd_ready !== 1'b1)
      fail_line("R10", "reset outputs", {res_valid, prot_err, cmd_ready}, 3'b001);
    rst_n = 1'b1;
    lk_miss(32'h0000_1000, "R10");
    lk_miss(32'hFFFF_FFFF, "R10");
    // R3: pending slot misses
    ins_a(32'h0000_5123, 20'hABCDE, "R3");
    lk_miss(32'h0000_5ABC, "R3");
    // R4: complete and read back
    ins_p(32'h0000_5800, PW1, 1'b0, "R4");
    lk_hit(32'h0000_5ABC, 32'hABCD_EABC, PW1, "R4");
    // R5: already valid, and not covered
    ins_p(32'h0000_5000, PW2, 1'b1, "R5");
    lk_hit(32'h0000_5010, 32'hABCD_E010, PW1, "R5");
    ins_p(32'h0000_9000, PW2, 1'b1, "R5");
    lk_miss(32'h0000_9000, "R5");
    // R1: range boundaries
    lk_hit(32'h0000_5000, 32'hABCD_E000, PW1, "R1");
    lk_hit(32'h0000_5FFF, 32'hABCD_EFFF, PW1, "R1");
    lk_miss(32'h0000_6000, "R1");
    lk_miss(32'h0000_4FFF, "R1");
    idle();
    // R6: reinsert over a valid covering slot
    ins_a(32'h0000_5000, 20'h11111, "R6");
    lk_miss(32'h0000_5004, "R6");
    ins_p(32'h0000_5000, PW2, 1'b0, "R6");
    lk_hit(32'h0000_5004, 32'h1111_1004, PW2, "R6");
    // R8: purge valid, then purge pending is ignored
    purge1(32'h0000_5FF0, "R8");
    lk_miss(32'h0000_5004, "R8");
    ins_a(32'h0000_7000, 20'h00777, "R8");
    purge1(32'h0000_7000, "R8");
    ins_p(32'h0000_7000, PWN, 1'b0, "R8");
    lk_hit(32'h0000_7ABC, 32'h0077_7ABC, PWN, "R8");
    // R9: purge-all
    purge_all("R9");
    lk_miss(32'h0000_7ABC, "R9");
    // R7: fill all slots, then round-robin eviction with wrap
    for (int k = 0; k < 16; k++) begin
      ins_a(32'((16 + k) << 12), 20'(256 + k), "R7");
      ins_p(32'((16 + k) << 12), PWN, 1'b0, "R7");
    end
    lk_hit(32'h0001_0020, 32'h0010_0020, PWN, "R7");
    lk_hit(32'h0001_F020, 32'h0010_F020, PWN, "R7");
    ins_a(32'h0004_0000, 20'h00400, "R7");   // evicts slot 0 (page 0x1F)
    lk_miss(32'h0001_F020, "R7");
    ins_p(32'h0004_0000, PW1, 1'b0, "R7");
    ins_a(32'h0004_1000, 20'h00401, "R7");   // evicts slot 1 (page 0x1E)
    ins_p(32'h0004_1000, PW1, 1'b0, "R7");
    lk_miss(32'h0001_E000, "R7");
    lk_hit(32'h0001_D000, 32'h0010_D000, PWN, "R7");
    for (int k = 2; k < 16; k++) begin
      ins_a(32'((64 + k) << 12), 20'(1024 + k), "R7");
      ins_p(32'((64 + k) << 12), PW1, 1'b0, "R7");
    end
    lk_hit(32'h0004_0008, 32'h0040_0008, PW1, "R7");
    ins_a(32'h0005_0000, 20'h00500, "R7");   // pointer wrapped: slot 0 again
    lk_miss(32'h0004_0008, "R7");
    lk_hit(32'h0004_1008, 32'h0040_1008, PW1, "R7");
    purge_all("R9");
    lk_miss(32'h0004_F000, "R9");
    idle();
    idle();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule